// File: doc/BRIEF.md
# Chained Edge Counter Bank with Snapshot Registers

This block keeps a bank of small edge counters, one for each input channel. Each counter counts single-cycle edge strobes from its channel, and each has a snapshot register next to it. A transfer event copies the running count into the snapshot register. On the same clock edge it restarts the counter, so no edge is lost between two snapshots. Two trigger schemes are available. In periodic mode, one shared event snapshots every channel at once. That event is a zero reached by an external down-counter, a write of zero to that counter, or a one-cycle software force strobe. In on-demand mode, each channel snapshots when the matching capture holding register is read.

Two controls change how a counter counts. A saturation control stops a counter at its all-ones value, which then means "that many or more edges". Without it, the counter wraps. Each pair of neighbouring channels can also be joined into one counter of twice the width. In that case, the lower channel's edges drive both halves and the pair snapshots as a unit. Every pin is a plain single-cycle strobe or level. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure: a strobe acts on the clock edge where it is high, and the outputs always show the current register contents.

Top module: `pulse_accum_bank`

## Requirements
- R1: While `rst_n` is low, every lane of `count_o` and `hold_o` reads zero.
- R2: For an unpaired channel with no transfer, an edge strobe adds one to its count on the next clock edge, and no strobe leaves the count unchanged. With saturation off, the all-ones value steps to zero.
- R3: For an unpaired channel with saturation on, the count stays at all-ones when further edges arrive.
- R4: With `queue_mode_i` = 0, a cycle in which any of `mod_zero_i`, `mod_wr_zero_i` or `force_latch_i` is high copies every channel's count into its `hold_o` lane and clears the count. In cycles without a transfer, `hold_o` keeps its value.
- R5: With `queue_mode_i` = 1 and channel i unpaired, `cap_rd_i[i]` transfers and clears only channel i. The other channels keep counting.
- R6: With `queue_mode_i` = 1, the three periodic strobes have no effect. With `queue_mode_i` = 0, `cap_rd_i` has no effect.
- R7: When an edge arrives in the same cycle as a transfer, the snapshot takes the old count and the count becomes 1 (0 when there is no edge).
- R8: With `pair_en_i[p]` = 1, channels 2p (low half) and 2p+1 (high half) form one counter of width 2·CNT_W. Edges on channel 2p increment it and carry into the high half. Edges on channel 2p+1 are ignored. Lane k of `count_o`/`hold_o` is bits [k·CNT_W +: CNT_W].
- R9: A paired counter saturates at all-ones of its full width when `sat_en_i` = 1, and wraps to zero when `sat_en_i` = 0.
- R10: A paired counter snapshots and clears both halves on the same edge. In on-demand mode, a read of either channel of the pair triggers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_i | input | NUM_CH | One active-edge strobe per channel |
| cap_rd_i | input | NUM_CH | Per-channel capture holding register read strobe (on-demand trigger) |
| queue_mode_i | input | 1 | 0: periodic snapshot mode, 1: on-demand snapshot mode |
| sat_en_i | input | 1 | 1: counters stop at all-ones instead of wrapping |
| pair_en_i | input | NUM_CH/2 | Bit p joins channels 2p and 2p+1 into one wide counter |
| mod_zero_i | input | 1 | External down-counter reached zero |
| mod_wr_zero_i | input | 1 | Zero was written to the external down-counter |
| force_latch_i | input | 1 | Software force-snapshot strobe, one cycle |
| count_o | output | NUM_CH*CNT_W | Running counts, lane per channel |
| hold_o | output | NUM_CH*CNT_W | Snapshot registers, lane per channel |

## Verification
The bench builds the bank with NUM_CH = 4 and CNT_W = 4. With 4-bit lanes, an unpaired lane wraps or saturates after 16 edges, and a joined pair reaches its 8-bit limit after 255 edges. Every wrap, carry and saturation corner can therefore be reached in a few hundred cycles. A pseudo-random sweep then runs through all combinations of the saturation setting, the trigger mode and the four pairing patterns, with edges, reads and periodic strobes mixed. A bench model computes the expected counts and snapshots arithmetically.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

  // Snapshot trigger scheme selected by queue_mode_i
  typedef enum logic {
    XFER_PERIODIC = 1'b0,
    XFER_ONDEMAND = 1'b1
  } xfer_mode_e;

  // Lane index helpers for a pair of neighbouring channels
  function automatic int lo_lane(input int pair_idx);
    return 2 * pair_idx;
  endfunction

  function automatic int hi_lane(input int pair_idx);
    return 2 * pair_idx + 1;
  endfunction

endpackage

// File: rtl/pacc_trigger.sv
module pacc_trigger
  import pacc_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_mode_e        mode_i,
  input  logic              mod_zero_i,
  input  logic              mod_wr_zero_i,
  input  logic              force_latch_i,
  input  logic [NUM_CH-1:0] cap_rd_i,
  input  logic [NUM_CH/2-1:0] pair_en_i,
  output logic [NUM_CH-1:0] xfer_o
);
  localparam int NUM_PAIR = NUM_CH / 2;

  logic periodic_evt;
  logic [NUM_CH-1:0] ondemand_evt;

  assign periodic_evt = mod_zero_i | mod_wr_zero_i | force_latch_i;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic rd_any;
    assign rd_any = cap_rd_i[lo_lane(p)] | cap_rd_i[hi_lane(p)];

    // A joined pair answers to a read of either of its channels
    always_comb begin
      if (pair_en_i[p]) begin
        ondemand_evt[lo_lane(p)] = rd_any;
        ondemand_evt[hi_lane(p)] = rd_any;
      end else begin
        ondemand_evt[lo_lane(p)] = cap_rd_i[lo_lane(p)];
        ondemand_evt[hi_lane(p)] = cap_rd_i[hi_lane(p)];
      end
    end

    AST_PAIR_XFER_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      pair_en_i[p] |-> (xfer_o[lo_lane(p)] == xfer_o[hi_lane(p)])); // R10
  end

  always_comb begin
    if (mode_i == XFER_ONDEMAND) xfer_o = ondemand_evt;
    else                         xfer_o = {NUM_CH{periodic_evt}};
  end

  AST_ONDEMAND_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == XFER_ONDEMAND && cap_rd_i == '0) |-> (xfer_o == '0)); // R6
  AST_PERIODIC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == XFER_PERIODIC && !mod_zero_i && !mod_wr_zero_i && !force_latch_i)
      |-> (xfer_o == '0)); // R6

endmodule

// File: rtl/pacc_pair.sv
module pacc_pair #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_en_i,
  input  logic             sat_en_i,
  input  logic             edge_lo_i,
  input  logic             edge_hi_i,
  input  logic             xfer_lo_i,
  input  logic             xfer_hi_i,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic [CNT_W-1:0] hold_lo_o,
  output logic [CNT_W-1:0] hold_hi_o
);
  localparam int WIDE_W = 2 * CNT_W;

  logic [WIDE_W-1:0] wide_cur, wide_nxt;
  logic [CNT_W-1:0]  lo_nxt, hi_nxt, hlo_nxt, hhi_nxt;
  logic [CNT_W-1:0]  solo_lo_nxt, solo_hi_nxt;

  assign wide_cur = {cnt_hi_o, cnt_lo_o};

  // Joined counter: edges of the low channel step the full-width value
  always_comb begin
    if (xfer_lo_i)
      wide_nxt = WIDE_W'(edge_lo_i);
    else if (edge_lo_i && !(sat_en_i && (&wide_cur)))
      wide_nxt = wide_cur + WIDE_W'(1);
    else
      wide_nxt = wide_cur;
  end

  // Independent lanes
  always_comb begin
    if (xfer_lo_i)
      solo_lo_nxt = CNT_W'(edge_lo_i);
    else if (edge_lo_i && !(sat_en_i && (&cnt_lo_o)))
      solo_lo_nxt = cnt_lo_o + CNT_W'(1);
    else
      solo_lo_nxt = cnt_lo_o;

    if (xfer_hi_i)
      solo_hi_nxt = CNT_W'(edge_hi_i);
    else if (edge_hi_i && !(sat_en_i && (&cnt_hi_o)))
      solo_hi_nxt = cnt_hi_o + CNT_W'(1);
    else
      solo_hi_nxt = cnt_hi_o;
  end

  always_comb begin
    if (pair_en_i) begin
      {hi_nxt, lo_nxt} = wide_nxt;
      hlo_nxt = xfer_lo_i ? cnt_lo_o : hold_lo_o;
      hhi_nxt = xfer_lo_i ? cnt_hi_o : hold_hi_o;
    end else begin
      lo_nxt  = solo_lo_nxt;
      hi_nxt  = solo_hi_nxt;
      hlo_nxt = xfer_lo_i ? cnt_lo_o : hold_lo_o;
      hhi_nxt = xfer_hi_i ? cnt_hi_o : hold_hi_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo_o  <= '0;
      cnt_hi_o  <= '0;
      hold_lo_o <= '0;
      hold_hi_o <= '0;
    end else begin
      cnt_lo_o  <= lo_nxt;
      cnt_hi_o  <= hi_nxt;
      hold_lo_o <= hlo_nxt;
      hold_hi_o <= hhi_nxt;
    end
  end

  AST_XFER_RESTART_LO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_lo_i |=> (cnt_lo_o == CNT_W'($past(edge_lo_i)))); // R7
  AST_XFER_SNAPSHOT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_lo_i |=> (hold_lo_o == $past(cnt_lo_o))); // R4
  AST_HOLD_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_lo_i |=> $stable(hold_lo_o)); // R4
  AST_PAIR_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en_i && xfer_lo_i) |=> (cnt_hi_o == '0 && hold_hi_o == $past(cnt_hi_o))); // R10
  AST_SAT_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_en_i && sat_en_i && !xfer_lo_i && (&cnt_lo_o)) |=> (&cnt_lo_o)); // R3
  AST_SAT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en_i && sat_en_i && !xfer_lo_i && (&wide_cur)) |=> (&{cnt_hi_o, cnt_lo_o})); // R9
  AST_HI_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_en_i && !xfer_lo_i && !edge_lo_i) |=> ($stable(cnt_hi_o) && $stable(cnt_lo_o))); // R8

endmodule

// File: rtl/pulse_accum_bank.sv
module pulse_accum_bank
  import pacc_pkg::*;
#(
  parameter int NUM_CH = 4,   // must be even: channels are joined in pairs
  parameter int CNT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         edge_i,
  input  logic [NUM_CH-1:0]         cap_rd_i,
  input  logic                      queue_mode_i,
  input  logic                      sat_en_i,
  input  logic [NUM_CH/2-1:0]       pair_en_i,
  input  logic                      mod_zero_i,
  input  logic                      mod_wr_zero_i,
  input  logic                      force_latch_i,
  output logic [NUM_CH*CNT_W-1:0]   count_o,
  output logic [NUM_CH*CNT_W-1:0]   hold_o
);
  localparam int NUM_PAIR = NUM_CH / 2;

  xfer_mode_e        mode;
  logic [NUM_CH-1:0] xfer;

  assign mode = queue_mode_i ? XFER_ONDEMAND : XFER_PERIODIC;

  pacc_trigger #(.NUM_CH(NUM_CH)) u_trig (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode),
    .mod_zero_i    (mod_zero_i),
    .mod_wr_zero_i (mod_wr_zero_i),
    .force_latch_i (force_latch_i),
    .cap_rd_i      (cap_rd_i),
    .pair_en_i     (pair_en_i),
    .xfer_o        (xfer)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam int LO = 2 * p;
    localparam int HI = 2 * p + 1;

    pacc_pair #(.CNT_W(CNT_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .pair_en_i (pair_en_i[p]),
      .sat_en_i  (sat_en_i),
      .edge_lo_i (edge_i[LO]),
      .edge_hi_i (edge_i[HI]),
      .xfer_lo_i (xfer[LO]),
      .xfer_hi_i (xfer[HI]),
      .cnt_lo_o  (count_o[LO*CNT_W +: CNT_W]),
      .cnt_hi_o  (count_o[HI*CNT_W +: CNT_W]),
      .hold_lo_o (hold_o[LO*CNT_W +: CNT_W]),
      .hold_hi_o (hold_o[HI*CNT_W +: CNT_W])
    );
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (count_o == '0 && hold_o == '0)); // R1

endmodule

// File: tb/sim_pulse_accum_bank.sv
module sim_pulse_accum_bank;
  localparam int NCH = 4;
  localparam int W   = 4;
  localparam int M   = 1 << W;
  localparam int NP  = NCH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] edge_s = '0, rd_s = '0;
  logic queue_s = 1'b0, sat_s = 1'b0;
  logic [NP-1:0] pair_s = '0;
  logic mz_s = 1'b0, wz_s = 1'b0, fl_s = 1'b0;
  logic [NCH*W-1:0] count_w, hold_w;

  int total = 0, bad = 0;
  int mcnt[NCH];
  int mhold[NCH];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pulse_accum_bank #(.NUM_CH(NCH), .CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_s), .cap_rd_i(rd_s),
    .queue_mode_i(queue_s), .sat_en_i(sat_s), .pair_en_i(pair_s),
    .mod_zero_i(mz_s), .mod_wr_zero_i(wz_s), .force_latch_i(fl_s),
    .count_o(count_w), .hold_o(hold_w)
  );

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      int gc, gh;
      gc = int'(count_w[c*W +: W]);
      gh = int'(hold_w[c*W +: W]);
      total++;
      if (gc != mcnt[c]) begin
        bad++;
        $display("FAIL %s count lane %0d actual=%0d expected=%0d", tag, c, gc, mcnt[c]);
      end
      total++;
      if (gh != mhold[c]) begin
        bad++;
        $display("FAIL %s hold lane %0d actual=%0d expected=%0d", tag, c, gh, mhold[c]);
      end
    end
  endtask

  // Expected behaviour from the requirements, evaluated on the inputs seen at the edge
  task automatic model_step();
    bit lt;
    lt = mz_s | wz_s | fl_s;
    for (int p = 0; p < NP; p++) begin
      int lo, hi;
      lo = 2 * p;
      hi = lo + 1;
      if (pair_s[p]) begin
        int v;
        bit x;
        v = mcnt[hi] * M + mcnt[lo];
        x = queue_s ? (rd_s[lo] | rd_s[hi]) : lt;
        if (x) begin
          mhold[lo] = v % M;
          mhold[hi] = v / M;
          v = int'(edge_s[lo]);
        end else if (edge_s[lo]) begin
          if (!(sat_s && v == M * M - 1)) v = (v + 1) % (M * M);
        end
        mcnt[lo] = v % M;
        mcnt[hi] = v / M;
      end else begin
        for (int k = 0; k < 2; k++) begin
          int c;
          bit x;
          c = lo + k;
          x = queue_s ? rd_s[c] : lt;
          if (x) begin
            mhold[c] = mcnt[c];
            mcnt[c] = int'(edge_s[c]);
          end else if (edge_s[c]) begin
            if (!(sat_s && mcnt[c] == M - 1)) mcnt[c] = (mcnt[c] + 1) % M;
          end
        end
      end
    end
  endtask

  // Inputs are set between edges; one clock; compare one time unit after the edge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    #1;
    check_all(tag);
  endtask

  task automatic drive(input logic [NCH-1:0] e, input logic [NCH-1:0] r,
                       input logic mz, input logic wz, input logic fl);
    edge_s = e; rd_s = r; mz_s = mz; wz_s = wz; fl_s = fl;
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin mcnt[c] = 0; mhold[c] = 0; end
    // R1: in reset with edges toggling
    edge_s = '1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    edge_s = '0;
    rst_n = 1'b1;

    // R2: lanes count at different rates, sat off, wrap reached
    for (int i = 0; i < 40; i++) begin
      drive(4'(i), '0, 0, 0, 0);
      cyc("R2");
    end
    // R3: saturation on, all lanes hammered
    sat_s = 1'b1;
    for (int i = 0; i < 20; i++) begin
      drive('1, '0, 0, 0, 0);
      cyc("R3");
    end
    sat_s = 1'b0;

    // R4: each periodic strobe, with and without edges (R7)
    drive(4'b0000, '0, 1, 0, 0); cyc("R4");
    drive(4'b1111, '0, 0, 0, 0); cyc("R4");
    drive(4'b0101, '0, 0, 1, 0); cyc("R7");
    drive(4'b1111, '0, 0, 0, 0); cyc("R4");
    drive(4'b1010, '0, 0, 0, 1); cyc("R7");
    drive(4'b0000, '0, 0, 0, 0); cyc("R4");
    // R6: reads ignored in periodic mode
    drive(4'b0011, 4'b1111, 0, 0, 0); cyc("R6");

    // R5 / R6: on-demand mode
    queue_s = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      drive('1, '0, 0, 0, 0); cyc("R5");
      drive(4'(c * 3), 4'(1 << c), 0, 0, 0); cyc("R5");
    end
    drive('1, '0, 1, 1, 1); cyc("R6");
    drive('0, '0, 0, 0, 0); cyc("R6");

    // R8 / R9: joined pairs, upper-channel edges injected
    pair_s = 2'b11;
    queue_s = 1'b0;
    drive('0, '0, 0, 0, 1); cyc("R10");
    for (int i = 0; i < 270; i++) begin
      drive({1'b1, 1'(i % 3 == 0), 1'b1, 1'(i % 2)}, '0, 0, 0, 0);
      cyc("R8");
    end
    queue_s = 1'b1;
    drive(4'b0101, 4'b1000, 0, 0, 0); cyc("R10");
    drive(4'b0000, 4'b0001, 0, 0, 0); cyc("R10");
    sat_s = 1'b1;
    for (int i = 0; i < 262; i++) begin
      drive(4'b0101, '0, 0, 0, 0);
      cyc("R9");
    end
    drive(4'b0001, 4'b0010, 0, 0, 0); cyc("R10");

    // Sweep of every sat / mode / pairing combination with pseudo-random stimulus
    for (int cfg = 0; cfg < 16; cfg++) begin
      sat_s = cfg[0];
      queue_s = cfg[1];
      pair_s = 2'(cfg >> 2);
      for (int i = 0; i < 300; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        drive(lfsr[3:0] | lfsr[7:4], lfsr[11:8] & lfsr[15:12] & lfsr[7:4],
              lfsr[5:0] == 6'd9, lfsr[9:4] == 6'd17, lfsr[12:7] == 6'd33);
        if (pair_s != 0) cyc("R8");
        else if (queue_s) cyc("R5");
        else cyc("R2");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule